// File: doc/BRIEF.md
# Six-Step Bridge Gate Sequencer

This block drives the six gates of a three-phase half-bridge for a sensorless brushless motor. It holds a seven-state machine. One state is a parking state that pulls the rotor to a known angle before start-up. The other six form the running commutation ring, and each pulse on the step strobe moves the ring on by one state. The strobe normally comes from an external oscillator that tracks the motor's back-EMF. For each state the block sets which low-side and high-side switches conduct. It also reports which undriven phase the back-EMF sampler should look at.

A chop input gates only the low-side switches, so an external speed loop or current limit can modulate the bridge without touching the high sides. Two overrides sit above normal operation. A brake request shorts the windings through all three low sides. An undervoltage flag turns every gate off and pulls a fault line low. When the machine leaves the parking state, the phase-C low side is held off for a programmable number of clocks after the phase-C high side has been seen released. This prevents shoot-through in that leg. Every gate output is registered.

Top module: `sixstep_gate_ctrl`

## Requirements
- R1: When `step_stb` is high and `align_req` is low at a clock edge, the state moves from park to step A, and otherwise around the ring A→B→C→D→E→F→A. The state code on `state_o` is park=0 and A..F=1..6.
- R2: While `rst_n` is low, `state_o` is 0, `lo_gate` is 000, `hi_gate_n` is 111 and `fault_n` is 1.
- R3: Gate outputs are registered, one clock after the state they reflect. With bit 0 = phase A, bit 1 = phase B and bit 2 = phase C, the conducting switches are: park: low B, high A and high C. A: low C, high A. B: low C, high B. C: low A, high B. D: low A, high C. E: low B, high C. F: low B, high A.
- R4: `smp_sel` names the phase to sample, registered like the gates: 0 = none, 1 = A, 2 = B, 3 = C. It is B in A and D, A in B and E, C in C and F, and none in park.
- R5: When `pwm_en` is low, all low-side gates are off one clock later. The high-side gates are unaffected.
- R6: After a park→A move, `lo_gate[2]` stays low for DEAD_CYC clocks after the clock in which `hi_gate_n[2]` first reads 1.
- R7: When `brake` is high (and `uv_flag` low), one clock later `lo_gate` is 111 and `hi_gate_n` is 111, regardless of `pwm_en`.
- R8: When `uv_flag` is high, one clock later `lo_gate` is 000, `hi_gate_n` is 111 and `fault_n` is 0. This takes priority over brake.
- R9: When `align_req` is high at a clock edge, the state becomes park, even if `step_stb` is high at the same edge.
- R10: No phase ever has its low-side and high-side gates on together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| align_req | input | 1 | Return to park state |
| step_stb | input | 1 | Advance one commutation step |
| pwm_en | input | 1 | Low-side chop enable |
| brake | input | 1 | Brake request, active high |
| uv_flag | input | 1 | Supply undervoltage, active high |
| lo_gate | output | 3 | Low-side gates, active high, bit 0 = phase A |
| hi_gate_n | output | 3 | High-side gates, active low, bit 0 = phase A |
| smp_sel | output | 2 | Phase to sample for back-EMF |
| fault_n | output | 1 | Undervoltage fault, active low |
| state_o | output | 3 | Current state code |

## Verification
The bench counts the exact clock in which the phase-C low side first turns on after leaving park. A design whose dead-time count is one clock short, or that does not wait for the high side to read released, turns it on too early. A design that never clears the count keeps it off for good.

It also applies brake and undervoltage together to check which one wins. A wrong priority shows up as all low sides on with the fault line asserted. Chop-off rows check that a design that also gates the high sides is caught. A same-edge align and step checks that the park request wins. A design with the wrong priority between them lands in step A instead of park.

// File: rtl/sixstep_gate_ctrl.sv
module sixstep_gate_ctrl #(
  parameter int DEAD_CYC = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       align_req,
  input  logic       step_stb,
  input  logic       pwm_en,
  input  logic       brake,
  input  logic       uv_flag,
  output logic [2:0] lo_gate,
  output logic [2:0] hi_gate_n,
  output logic [1:0] smp_sel,
  output logic       fault_n,
  output logic [2:0] state_o
);

  localparam int CW = $clog2(DEAD_CYC + 1);
  localparam logic [2:0] ST_P = 3'd0;
  localparam logic [2:0] ST_A = 3'd1;
  localparam logic [2:0] ST_F = 3'd6;

  logic [2:0]    st_q, st_d;
  logic [CW-1:0] dead_q;
  logic [2:0]    lo_raw, hi_raw_n, lo_nxt, hi_nxt_n;
  logic [1:0]    sel_raw;
  logic          lc_ok;

  always_comb begin
    st_d = st_q;
    if (align_req)
      st_d = ST_P;
    else if (step_stb)
      st_d = (st_q == ST_P || st_q == ST_F) ? ST_A : st_q + 3'd1;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) st_q <= ST_P;
    else        st_q <= st_d;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)
      dead_q <= '0;
    else if (st_q == ST_P && st_d == ST_A)
      dead_q <= CW'(DEAD_CYC);
    else if (dead_q != '0)
      dead_q <= dead_q - 1'b1;

  always_comb begin
    unique case (st_q)
      3'd0:    begin lo_raw = 3'b010; hi_raw_n = 3'b010; sel_raw = 2'd0; end
      3'd1:    begin lo_raw = 3'b100; hi_raw_n = 3'b110; sel_raw = 2'd2; end
      3'd2:    begin lo_raw = 3'b100; hi_raw_n = 3'b101; sel_raw = 2'd1; end
      3'd3:    begin lo_raw = 3'b001; hi_raw_n = 3'b101; sel_raw = 2'd3; end
      3'd4:    begin lo_raw = 3'b001; hi_raw_n = 3'b011; sel_raw = 2'd2; end
      3'd5:    begin lo_raw = 3'b010; hi_raw_n = 3'b011; sel_raw = 2'd1; end
      3'd6:    begin lo_raw = 3'b010; hi_raw_n = 3'b110; sel_raw = 2'd3; end
      default: begin lo_raw = 3'b000; hi_raw_n = 3'b111; sel_raw = 2'd0; end
    endcase
  end

  assign lc_ok = (dead_q == '0) && hi_gate_n[2];

  always_comb begin
    if (uv_flag) begin
      lo_nxt   = 3'b000;
      hi_nxt_n = 3'b111;
    end else if (brake) begin
      lo_nxt   = 3'b111;
      hi_nxt_n = 3'b111;
    end else begin
      lo_nxt   = lo_raw & {3{pwm_en}} & {lc_ok, 2'b11};
      hi_nxt_n = hi_raw_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      lo_gate   <= 3'b000;
      hi_gate_n <= 3'b111;
      smp_sel   <= 2'd0;
      fault_n   <= 1'b1;
    end else begin
      lo_gate   <= lo_nxt;
      hi_gate_n <= hi_nxt_n;
      smp_sel   <= sel_raw;
      fault_n   <= !uv_flag;
    end

  assign state_o = st_q;

  // R1
  ring_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_stb && !align_req && st_q != ST_P) |=>
      st_q == (($past(st_q) == ST_F) ? ST_A : $past(st_q) + 3'd1));

  // R9
  align_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    align_req |=> st_q == ST_P);

  // R5
  chop_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwm_en && !brake) |=> lo_gate == 3'b000);

  // R6
  phase_c_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_gate[2] && !$past(brake)) |-> $past(hi_gate_n[2]));

  // R7
  brake_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (brake && !uv_flag) |=> (lo_gate == 3'b111 && hi_gate_n == 3'b111));

  // R8
  uv_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uv_flag |=> (lo_gate == 3'b000 && hi_gate_n == 3'b111 && !fault_n));

  // R10
  no_shoot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_gate & ~hi_gate_n) == 3'b000);

endmodule

// File: tb/tb_sixstep_gate_ctrl.sv
module tb_sixstep_gate_ctrl;
  localparam int D = 3;

  logic clk = 0, rst_n = 0;
  logic align_req = 0, step_stb = 0, pwm_en = 1, brake = 0, uv_flag = 0;
  logic [2:0] lo_gate, hi_gate_n, state_o;
  logic [1:0] smp_sel;
  logic fault_n;
  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sixstep_gate_ctrl #(.DEAD_CYC(D)) dut (
    .clk(clk), .rst_n(rst_n), .align_req(align_req), .step_stb(step_stb),
    .pwm_en(pwm_en), .brake(brake), .uv_flag(uv_flag), .lo_gate(lo_gate),
    .hi_gate_n(hi_gate_n), .smp_sel(smp_sel), .fault_n(fault_n), .state_o(state_o));

  // fields: stb pwm brk uv | state lo hi_n sel fault_n
  localparam logic [15:0] VEC [12] = '{
    {1'b1,1'b1,1'b0,1'b0, 3'd2,3'b100,3'b101,2'd1,1'b1},
    {1'b1,1'b1,1'b0,1'b0, 3'd3,3'b001,3'b101,2'd3,1'b1},
    {1'b1,1'b0,1'b0,1'b0, 3'd4,3'b000,3'b011,2'd2,1'b1},
    {1'b1,1'b1,1'b0,1'b0, 3'd5,3'b010,3'b011,2'd1,1'b1},
    {1'b1,1'b0,1'b0,1'b0, 3'd6,3'b000,3'b110,2'd3,1'b1},
    {1'b1,1'b1,1'b0,1'b0, 3'd1,3'b100,3'b110,2'd2,1'b1},
    {1'b0,1'b1,1'b1,1'b0, 3'd1,3'b111,3'b111,2'd2,1'b1},
    {1'b0,1'b0,1'b1,1'b0, 3'd1,3'b111,3'b111,2'd2,1'b1},
    {1'b1,1'b1,1'b0,1'b1, 3'd2,3'b000,3'b111,2'd1,1'b0},
    {1'b0,1'b1,1'b1,1'b1, 3'd2,3'b000,3'b111,2'd1,1'b0},
    {1'b0,1'b1,1'b0,1'b0, 3'd2,3'b100,3'b101,2'd1,1'b1},
    {1'b1,1'b0,1'b1,1'b0, 3'd3,3'b111,3'b111,2'd3,1'b1}
  };

  function automatic logic [11:0] obs();
    return {state_o, lo_gate, hi_gate_n, smp_sel, fault_n};
  endfunction

  task automatic chk(string tag, logic [11:0] act, logic [11:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    // R2 reset state
    chk("R2 reset", obs(), {3'd0, 3'b000, 3'b111, 2'd0, 1'b1});
    rst_n = 1;
    tick();
    // R3 R4 park outputs
    chk("R3 R4 park", obs(), {3'd0, 3'b010, 3'b010, 2'd0, 1'b1});

    // R6 phase-C dead time after leaving park
    step_stb = 1;
    tick();
    step_stb = 0;
    chk("R1 park to A", obs(), {3'd1, 3'b010, 3'b010, 2'd0, 1'b1});
    tick();
    chk("R6 hc released lc held", obs(), {3'd1, 3'b000, 3'b110, 2'd2, 1'b1});
    for (int k = 0; k < D - 1; k++) begin
      tick();
      chk("R6 lc still held", obs(), {3'd1, 3'b000, 3'b110, 2'd2, 1'b1});
    end
    tick();
    chk("R6 lc on after gap", obs(), {3'd1, 3'b100, 3'b110, 2'd2, 1'b1});

    // table walk: R1 R3 R4 R5 R7 R8
    for (int i = 0; i < 12; i++) begin
      step_stb = VEC[i][15];
      pwm_en   = VEC[i][14];
      brake    = VEC[i][13];
      uv_flag  = VEC[i][12];
      @(posedge clk);
      @(negedge clk);
      step_stb = 0;
      tick();
      chk($sformatf("R1 R3 R4 R5 R7 R8 row %0d", i), obs(), VEC[i][11:0]);
    end
    brake = 0; uv_flag = 0; pwm_en = 1;

    // R9 align wins over a same-edge step
    align_req = 1; step_stb = 1;
    tick();
    align_req = 0; step_stb = 0;
    chk("R9 align over step", {9'd0, state_o}, {9'd0, 3'd0});
    tick();
    chk("R9 park outputs", obs(), {3'd0, 3'b010, 3'b010, 2'd0, 1'b1});

    // R5 chop leaves high sides on in park
    pwm_en = 0;
    tick();
    chk("R5 chop park", obs(), {3'd0, 3'b000, 3'b010, 2'd0, 1'b1});
    pwm_en = 1;

    // R8 fault releases on recovery
    uv_flag = 1;
    tick();
    chk("R8 uv in park", obs(), {3'd0, 3'b000, 3'b111, 2'd0, 1'b0});
    uv_flag = 0;
    tick();
    chk("R8 uv cleared", obs(), {3'd0, 3'b010, 3'b010, 2'd0, 1'b1});

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end
endmodule